// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A frame is a low start bit, then 7, 8 or 9 data bits in either bit order, then an optional parity bit, then one or two high stop bits. A 7-bit control word selects the format. The block samples that word, together with the data word, at the moment it accepts a load strobe. Changes to either input during a frame have no effect.

Each bit is held for exactly one period of an external baud-enable tick, which the block receives from a rate generator outside it. The line idles high. A busy flag is high from the moment a word is accepted until the frame has finished. A one-cycle end pulse is raised only once the last stop bit has fully left the line. The parity options are none, a constant zero bit, even parity and odd parity. Even and odd parity are computed over the data bits of the selected length only.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever busy_o is low, txd_o is high; after reset busy_o and done_o are low.
- R2: A load_i pulse with tx_en_i high and busy_o low is accepted, and busy_o is high from the next cycle. The first baud_tick_i after acceptance starts a low start bit, and every later bit is held for exactly one baud tick.
- R3: ctrl_i[1:0] sets the data length: 01 = 9 bits (data_i[8:0]), 10 = 7 bits (data_i[6:0]), 11 = 8 bits (data_i[7:0]), and the prohibited 00 behaves as 8 bits. Unused upper data bits are never sent.
- R4: ctrl_i[6] sets the bit order: 0 sends the most significant bit of the selected length first, 1 sends bit 0 first.
- R5: ctrl_i[5:4] sets the parity bit after the data: 00 = none, 01 = always 0, 10 = even (total of ones in the data and parity is even), 11 = odd.
- R6: ctrl_i[3:2] = 10 gives two high stop bits. Codes 01, 00 and 11 give one stop bit.
- R7: done_o pulses high for exactly one cycle, in the cycle after the tick that ends the last stop bit. busy_o falls in that same cycle.
- R8: A load_i pulse while tx_en_i is low is ignored, and the line stays idle.
- R9: A load_i pulse while busy_o is high is ignored, and the frame in flight is sent unchanged.
- R10: data_i and ctrl_i are captured at acceptance. Changing them during a frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en_i | input | 1 | Transmit enable; loads are accepted only when high |
| load_i | input | 1 | Load strobe for data_i and ctrl_i |
| data_i | input | DATA_W (9) | Data word to send |
| ctrl_i | input | 7 | Frame format: [6] order, [5:4] parity, [3:2] stop, [1:0] length |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest situation to reach is a load that arrives in the middle of a frame while data_i and ctrl_i are also being changed. Only a correct capture at acceptance keeps the line unchanged in that case. The stimulus starts a frame and then overwrites both inputs with inverted values. A few ticks later it issues a second load with a different format. A scoreboard of per-bit expectations, built from the first word alone, then shows whether any bit was disturbed. Format corners such as the prohibited length code, invalid stop codes and zero parity on all-ones data are each driven as their own frame.

// File: rtl/ufx_pkg.sv
package ufx_pkg;

    localparam int UFX_DATA_W = 9;
    localparam int UFX_CTRL_W = 7;

    // control word layout, MSB to LSB: order, parity, stop, length
    typedef struct packed {
        logic       lsb_first;
        logic [1:0] par;
        logic [1:0] stop;
        logic [1:0] len;
    } ufx_ctrl_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        LEN_SHORT = 2'b00,  // DATA_W-2 bits
        LEN_MID   = 2'b01,  // DATA_W-1 bits
        LEN_FULL  = 2'b10   // DATA_W bits
    } len_sel_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PEND  = 3'd1,
        PH_START = 3'd2,
        PH_DATA  = 3'd3,
        PH_PAR   = 3'd4,
        PH_STOP  = 3'd5
    } phase_e;

endpackage

// File: rtl/ufx_fmt_decode.sv
module ufx_fmt_decode
    import ufx_pkg::*;
#(
    parameter int DATA_W = UFX_DATA_W,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [UFX_CTRL_W-1:0] ctrl_i,
    output len_sel_e              len_sel_o,
    output logic [CNT_W-1:0]      nbits_o,
    output logic                  two_stop_o,
    output logic                  lsb_first_o,
    output par_mode_e             par_mode_o
);

    ufx_ctrl_t c;
    assign c = ufx_ctrl_t'(ctrl_i);

    always_comb begin
        unique case (c.len)
            2'b01:   begin len_sel_o = LEN_FULL;  nbits_o = CNT_W'(DATA_W);     end
            2'b10:   begin len_sel_o = LEN_SHORT; nbits_o = CNT_W'(DATA_W - 2); end
            default: begin len_sel_o = LEN_MID;   nbits_o = CNT_W'(DATA_W - 1); end
        endcase
    end

    // only code 10 asks for two stop bits; anything else falls back to one
    assign two_stop_o  = (c.stop == 2'b10);
    assign lsb_first_o = c.lsb_first;
    assign par_mode_o  = par_mode_e'(c.par);

endmodule

// File: rtl/ufx_order.sv
module ufx_order
    import ufx_pkg::*;
#(
    parameter int DATA_W = UFX_DATA_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  len_sel_e          len_sel_i,
    input  logic              lsb_first_i,
    output logic [DATA_W-1:0] masked_o,
    output logic [DATA_W-1:0] ordered_o
);

    localparam int L_S = DATA_W - 2;
    localparam int L_M = DATA_W - 1;
    localparam int L_F = DATA_W;

    logic [DATA_W-1:0] rev;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam bit IN_S = (i < L_S);
        localparam bit IN_M = (i < L_M);
        localparam int IX_S = IN_S ? (L_S - 1 - i) : 0;
        localparam int IX_M = IN_M ? (L_M - 1 - i) : 0;
        localparam int IX_F = L_F - 1 - i;

        logic sel_s, sel_m, sel_f;
        assign sel_s = (len_sel_i == LEN_SHORT);
        assign sel_m = (len_sel_i == LEN_MID);
        assign sel_f = (len_sel_i == LEN_FULL);

        assign masked_o[i] = data_i[i] & ((sel_s & IN_S) | (sel_m & IN_M) | sel_f);
        assign rev[i] = (sel_s & IN_S & data_i[IX_S])
                      | (sel_m & IN_M & data_i[IX_M])
                      | (sel_f & data_i[IX_F]);
    end

    // shift register always sends bit 0 first
    assign ordered_o = lsb_first_i ? masked_o : rev;

endmodule

// File: rtl/ufx_parity.sv
module ufx_parity
    import ufx_pkg::*;
#(
    parameter int DATA_W = UFX_DATA_W
) (
    input  logic [DATA_W-1:0] masked_i,
    input  par_mode_e         mode_i,
    output logic              par_en_o,
    output logic              par_bit_o
);

    logic ones_odd;
    assign ones_odd = ^masked_i;

    always_comb begin
        par_en_o  = 1'b1;
        par_bit_o = 1'b0;
        unique case (mode_i)
            PAR_NONE: par_en_o  = 1'b0;
            PAR_ZERO: par_bit_o = 1'b0;
            PAR_EVEN: par_bit_o = ones_odd;
            PAR_ODD:  par_bit_o = ~ones_odd;
            default:  par_en_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import ufx_pkg::*;
#(
    parameter int DATA_W = UFX_DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_en_i,
    input  logic                  load_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic [UFX_CTRL_W-1:0] ctrl_i,
    input  logic                  baud_tick_i,
    output logic                  txd_o,
    output logic                  busy_o,
    output logic                  done_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              par_en;
        logic              par_bit;
        logic              stop_more;
        logic              txd;
        logic              busy;
        logic              done;
    } state_t;

    // reset format: 8 data bits, no parity, single stop
    localparam state_t ST_RST = '{
        phase:     PH_IDLE,
        shreg:     '0,
        cnt:       CNT_W'(DATA_W - 2),
        par_en:    1'b0,
        par_bit:   1'b0,
        stop_more: 1'b0,
        txd:       1'b1,
        busy:      1'b0,
        done:      1'b0
    };

    len_sel_e          len_sel;
    logic [CNT_W-1:0]  nbits;
    logic              two_stop;
    logic              lsb_first;
    par_mode_e         par_mode;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] ordered;
    logic              par_en;
    logic              par_bit;

    ufx_fmt_decode #(.DATA_W(DATA_W)) u_dec (
        .ctrl_i      (ctrl_i),
        .len_sel_o   (len_sel),
        .nbits_o     (nbits),
        .two_stop_o  (two_stop),
        .lsb_first_o (lsb_first),
        .par_mode_o  (par_mode)
    );

    ufx_order #(.DATA_W(DATA_W)) u_ord (
        .data_i      (data_i),
        .len_sel_i   (len_sel),
        .lsb_first_i (lsb_first),
        .masked_o    (masked),
        .ordered_o   (ordered)
    );

    ufx_parity #(.DATA_W(DATA_W)) u_par (
        .masked_i  (masked),
        .mode_i    (par_mode),
        .par_en_o  (par_en),
        .par_bit_o (par_bit)
    );

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (load_i && tx_en_i) begin
                    st_d.phase     = PH_PEND;
                    st_d.busy      = 1'b1;
                    st_d.shreg     = ordered;
                    st_d.cnt       = nbits - CNT_W'(1);
                    st_d.par_en    = par_en;
                    st_d.par_bit   = par_bit;
                    st_d.stop_more = two_stop;
                end
            end
            PH_PEND: begin
                if (baud_tick_i) begin
                    st_d.phase = PH_START;
                    st_d.txd   = 1'b0;
                end
            end
            PH_START: begin
                if (baud_tick_i) begin
                    st_d.phase = PH_DATA;
                    st_d.txd   = st_q.shreg[0];
                    st_d.shreg = st_q.shreg >> 1;
                end
            end
            PH_DATA: begin
                if (baud_tick_i) begin
                    if (st_q.cnt == '0) begin
                        if (st_q.par_en) begin
                            st_d.phase = PH_PAR;
                            st_d.txd   = st_q.par_bit;
                        end else begin
                            st_d.phase = PH_STOP;
                            st_d.txd   = 1'b1;
                        end
                    end else begin
                        st_d.txd   = st_q.shreg[0];
                        st_d.shreg = st_q.shreg >> 1;
                        st_d.cnt   = st_q.cnt - CNT_W'(1);
                    end
                end
            end
            PH_PAR: begin
                if (baud_tick_i) begin
                    st_d.phase = PH_STOP;
                    st_d.txd   = 1'b1;
                end
            end
            PH_STOP: begin
                if (baud_tick_i) begin
                    if (st_q.stop_more) begin
                        st_d.stop_more = 1'b0;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                    end
                end
            end
            default: st_d = ST_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign txd_o  = st_q.txd;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/ufx_checker.sv
module ufx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en_i,
    input logic load_i,
    input logic baud_tick_i,
    input logic txd_o,
    input logic busy_o,
    input logic done_o
);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && tx_en_i && !busy_o) |=> busy_o);

    p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !baud_tick_i) |=> $stable(txd_o));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(busy_o) && !busy_o));

    p_ignore_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && load_i && !tx_en_i) |=> !busy_o);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !baud_tick_i) |=> busy_o);

endmodule

bind uart_frame_tx ufx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en_i),
    .load_i      (load_i),
    .baud_tick_i (baud_tick_i),
    .txd_o       (txd_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 3;
    localparam int WDOG_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       load = 1'b0;
    logic [8:0] data = '0;
    logic [6:0] ctrl = '0;
    logic       tick = 1'b0;
    logic       txd, busy, done;
    int         tick_cnt = 0;

    int total = 0;
    int bad   = 0;

    // expectation queues, pushed and popped together
    logic  q_val[$];
    int    q_kind[$];   // 0 = line bit, 1 = end of frame
    string q_tag[$];
    string idle_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_frame_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en_i     (tx_en),
        .load_i      (load),
        .data_i      (data),
        .ctrl_i      (ctrl),
        .baud_tick_i (tick),
        .txd_o       (txd),
        .busy_o      (busy),
        .done_o      (done)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= 0;
            tick     <= 1'b0;
        end else begin
            tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
            tick     <= (tick_cnt == TICK_DIV - 1);
        end
    end

    task automatic check3(input string tag, input logic t, input logic b,
                          input logic d, input logic et, input logic eb, input logic ed);
        total++;
        if (t !== et || b !== eb || d !== ed) begin
            bad++;
            $display("FAIL %s: txd/busy/done got %b%b%b expected %b%b%b",
                     tag, t, b, d, et, eb, ed);
        end
    endtask

    // monitor: after every consumed tick compare the line with the next item
    logic pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            if (q_val.size() != 0) begin
                logic  v;
                int    k;
                string tg;
                v  = q_val.pop_front();
                k  = q_kind.pop_front();
                tg = q_tag.pop_front();
                if (k == 1) check3(tg, txd, busy, done, 1'b1, 1'b0, 1'b1);
                else        check3(tg, txd, busy, done, v, 1'b1, 1'b0);
            end else begin
                check3(idle_tag, txd, busy, done, 1'b1, 1'b0, 1'b0);
            end
        end
        pend = tick && rst_n;
    end

    task automatic push(input logic v, input int k, input string tg);
        q_val.push_back(v);
        q_kind.push_back(k);
        q_tag.push_back(tg);
    endtask

    // build the expected frame from the requirements, then load it
    task automatic start_frame(input logic [8:0] d, input logic [6:0] c, input string tg);
        int   n;
        logic p;
        n = (c[1:0] == 2'b01) ? 9 : (c[1:0] == 2'b10) ? 7 : 8;
        p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        @(negedge clk);
        while (tick) @(negedge clk);
        #1;
        push(1'b0, 0, "R2");
        for (int i = 0; i < n; i++) push(c[6] ? d[i] : d[n-1-i], 0, tg);
        case (c[5:4])
            2'b01: push(1'b0, 0, "R5");
            2'b10: push(p, 0, "R5");
            2'b11: push(~p, 0, "R5");
            default: ;
        endcase
        push(1'b1, 0, "R6");
        if (c[3:2] == 2'b10) push(1'b1, 0, "R6");
        push(1'b1, 1, "R7");
        data = d;
        ctrl = c;
        load = 1'b1;
        @(negedge clk);
        #1;
        load = 1'b0;
    endtask

    task automatic drain();
        while (q_val.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [8:0] d, input logic [6:0] c, input string tg);
        start_frame(d, c, tg);
        drain();
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check3("R1", txd, busy, done, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check3("R1", txd, busy, done, 1'b1, 1'b0, 1'b0);

        // R8: load with transmit disabled
        idle_tag = "R8";
        @(negedge clk); #1;
        data = 9'h0F0; ctrl = 7'b1_00_01_11; load = 1'b1;
        @(negedge clk); #1;
        load = 1'b0;
        @(negedge clk);
        check3("R8", txd, busy, done, 1'b1, 1'b0, 1'b0);
        repeat (12) @(negedge clk);
        idle_tag = "R1";
        tx_en = 1'b1;

        // ctrl: [6] order, [5:4] parity, [3:2] stop, [1:0] length
        frame(9'h0A5, 7'b1_00_01_11, "R4");   // 8 bit, lsb first
        frame(9'h0A5, 7'b0_10_01_11, "R4");   // 8 bit, msb first, even
        frame(9'h13C, 7'b0_11_10_10, "R3");   // 7 bit, odd, two stop
        frame(9'h1FF, 7'b1_01_01_01, "R3");   // 9 bit, zero parity
        frame(9'h1FF, 7'b0_11_01_01, "R5");   // 9 bit, odd, msb first
        frame(9'h0B3, 7'b1_10_00_00, "R3");   // prohibited length, stop 00
        frame(9'h0B3, 7'b0_00_11_00, "R6");   // stop 11 falls back to one
        frame(9'h041, 7'b1_11_10_10, "R5");   // 7 bit odd parity, two stop

        // R9 and R10: disturb inputs and retry load while busy
        start_frame(9'h156, 7'b0_10_10_01, "R10");
        #1;
        data = ~9'h156;
        ctrl = ~7'b0_10_10_01;
        repeat (8) @(negedge clk);
        #1;
        data = 9'h000; ctrl = 7'b1_00_01_10; load = 1'b1;
        @(negedge clk); #1;
        load = 1'b0;
        drain();

        start_frame(9'h0C3, 7'b1_01_01_11, "R9");
        repeat (20) @(negedge clk);
        #1;
        data = 9'h1FF; load = 1'b1;
        @(negedge clk); #1;
        load = 1'b0;
        drain();

        repeat (3 * TICK_DIV) @(negedge clk);
        finish_run();
    end

endmodule